// File: doc/BRIEF.md
# Dual-mode interrupt status aggregator

This block gathers interrupt causes into a single 32-bit pending word and turns that word into an interrupt indication for a host. Causes arrive in two ways. Hardware units, such as a compute engine and a DMA engine, deliver single-cycle request pulses. Software writes a mask to a raise offset to set bits, or to an acknowledge offset to clear them. The pending word can be read back at a status offset.

A mode input selects how the host is told about pending bits.

- **Level mode:** a level interrupt line rises when a raise leaves any bit pending. The line falls only when a clear leaves the word empty.
- **Message mode:** every raise that leaves any bit pending produces a one-clock notification pulse, even if the same bits were already pending. In this mode a clear never lowers the line. The bus transaction that carries the message is built elsewhere, from that pulse.

The register port accepts one write per cycle and has no back-pressure: a write cycle is always taken. Reads are combinational on the current pending word. The pending word, the line and the pulse all change on the clock edge that follows the causing cycle.

Top module: `irq_pend_agg`

## Requirements
- R1: While reset is asserted, the pending word reads 0, and `irq_line` and `msg_pulse` are low.
- R2: A write to offset 0x60 ORs the written data into the pending word. The new value is visible at offset 0x24 from the next cycle.
- R3: A write to offset 0x64 clears every pending bit that is 1 in the written data and leaves the other bits unchanged.
- R4: A pulse on `hw_req[0]` (compute done) sets pending bit 0, and a pulse on `hw_req[1]` (DMA done) sets pending bit 8.
- R5: A software raise and hardware requests in the same cycle merge into one OR update, so no cause is lost.
- R6: When a bit is both raised and cleared in the same cycle, the bit ends set.
- R7: In level mode (`msg_mode`=0), a raise that leaves the pending word non-zero drives `irq_line` high in the next cycle.
- R8: In level mode, `irq_line` falls only after a clear that leaves the pending word zero. A partial clear keeps the line high.
- R9: In message mode (`msg_mode`=1), every raise that leaves the word non-zero drives `msg_pulse` high for the next cycle, including a raise of bits that are already pending. A raise that leaves the word zero gives no pulse.
- R10: In message mode, neither raises nor clears change `irq_line`.
- R11: In level mode, `msg_pulse` stays low.
- R12: Reads at any offset other than 0x24 return 0. Writes to any offset other than 0x60 and 0x64 leave the pending word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_mode | input | 1 | 1 selects message mode, 0 selects level mode |
| hw_req | input | 2 | Hardware cause pulses: bit 0 is compute done, bit 1 is DMA done |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data (mask) |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Read data: the pending word at 0x24, otherwise 0 |
| irq_line | output | 1 | Level interrupt line |
| msg_pulse | output | 1 | One-cycle notification pulse for message mode |

## Verification
The bench targets these corner cases, and what a wrong design would do in each:

- **Raise of bits already pending in message mode.** A design that fires only on new bits would stay silent.
- **Mode switched while the line is high, then everything cleared.** A design that drops the line on any emptying clear would release the line in message mode.
- **Partial acknowledge in level mode.** A design that ignores the remaining bits would lower the line early.
- **Hardware raise coinciding with a software acknowledge of the same bit, and with a software raise.** Giving the clear priority, or letting one source overwrite the other, loses a cause.

Random traffic across the raise, clear and unused offsets, in both modes, is compared against a bench model.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int IRQ_W = 32;
  localparam int POS_W = $clog2(IRQ_W);

  typedef struct packed {
    logic [IRQ_W-1:0] set_mask;
    logic [IRQ_W-1:0] clr_mask;
    logic             raise;
    logic             clear;
  } irq_req_t;
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RAISE_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] CLEAR_OFS = 8'h64,
  parameter int NUM_HW = 2,
  parameter logic [NUM_HW*POS_W-1:0] HW_POS = {5'd8, 5'd0}
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IRQ_W-1:0]  wr_data,
  input  logic [NUM_HW-1:0] hw_req,
  output irq_req_t          req
);
  logic [IRQ_W-1:0] hw_vec [NUM_HW];
  logic [IRQ_W-1:0] hw_mask;
  logic sw_raise, sw_clear;

  for (genvar g = 0; g < NUM_HW; g++) begin : g_src
    assign hw_vec[g] = hw_req[g] ? (IRQ_W'(1) << HW_POS[g*POS_W +: POS_W]) : '0;
  end

  always_comb begin
    hw_mask = '0;
    for (int i = 0; i < NUM_HW; i++) hw_mask = hw_mask | hw_vec[i];
  end

  assign sw_raise = wr_en && (wr_addr == RAISE_OFS);
  assign sw_clear = wr_en && (wr_addr == CLEAR_OFS);

  always_comb begin
    req.set_mask = hw_mask | (sw_raise ? wr_data : '0);
    req.clr_mask = sw_clear ? wr_data : '0;
    req.raise    = sw_raise || (|hw_req);
    req.clear    = sw_clear;
  end
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  irq_req_t         req,
  output logic [IRQ_W-1:0] pend_q,
  output logic [IRQ_W-1:0] pend_d
);
  // Set is applied after clear, so a raise beats a same-cycle clear.
  assign pend_d = (pend_q & ~req.clr_mask) | req.set_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
  import irq_pend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_mode,
  input  logic             raise,
  input  logic             clear,
  input  logic [IRQ_W-1:0] pend_d,
  output logic             irq_line,
  output logic             msg_pulse
);
  logic any_d;
  assign any_d = |pend_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_line  <= 1'b0;
      msg_pulse <= 1'b0;
    end else begin
      msg_pulse <= msg_mode && raise && any_d;
      if (!msg_mode) begin
        if (raise && any_d)       irq_line <= 1'b1;
        else if (clear && !any_d) irq_line <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] RAISE_OFS  = 8'h60,
  parameter logic [ADDR_W-1:0] CLEAR_OFS  = 8'h64,
  parameter int NUM_HW = 2,
  parameter logic [NUM_HW*POS_W-1:0] HW_POS = {5'd8, 5'd0}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic [NUM_HW-1:0] hw_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IRQ_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [IRQ_W-1:0]  rd_data,
  output logic              irq_line,
  output logic              msg_pulse
);
  irq_req_t         req;
  logic [IRQ_W-1:0] pend_q, pend_d;

  irq_req_decode #(
    .ADDR_W(ADDR_W), .RAISE_OFS(RAISE_OFS), .CLEAR_OFS(CLEAR_OFS),
    .NUM_HW(NUM_HW), .HW_POS(HW_POS)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_req(hw_req), .req(req)
  );

  irq_pend_reg u_reg (
    .clk(clk), .rst_n(rst_n), .req(req), .pend_q(pend_q), .pend_d(pend_d)
  );

  irq_out_gen u_out (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
    .raise(req.raise), .clear(req.clear), .pend_d(pend_d),
    .irq_line(irq_line), .msg_pulse(msg_pulse)
  );

  assign rd_data = (rd_addr == STATUS_OFS) ? pend_q : '0;
endmodule

// File: rtl/irq_pend_agg_chk.sv
module irq_pend_agg_chk
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RAISE_OFS = 8'h60,
  parameter logic [ADDR_W-1:0] CLEAR_OFS = 8'h64,
  parameter int NUM_HW = 2,
  parameter logic [NUM_HW*POS_W-1:0] HW_POS = {5'd8, 5'd0}
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_mode,
  input logic [NUM_HW-1:0] hw_req,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq_line,
  input logic              msg_pulse,
  input logic [IRQ_W-1:0]  pend_q
);
  logic raise_seen, clear_seen;
  assign raise_seen = (wr_en && wr_addr == RAISE_OFS) || (|hw_req);
  assign clear_seen = wr_en && wr_addr == CLEAR_OFS;

  a_r11_no_pulse_level: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> !msg_pulse);

  a_r9_pulse_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> pend_q != '0);

  a_r9_pulse_from_raise: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_seen |=> !msg_pulse);

  a_r10_msg_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> $stable(irq_line));

  a_r7_level_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_seen && !msg_mode) |=> (pend_q == '0 || irq_line));

  a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line && !(clear_seen && !msg_mode)) |=> irq_line);

  a_r6_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req[0] && clear_seen) |=> pend_q[HW_POS[POS_W-1:0]]);
endmodule

bind irq_pend_agg irq_pend_agg_chk #(
  .ADDR_W(ADDR_W), .RAISE_OFS(RAISE_OFS), .CLEAR_OFS(CLEAR_OFS),
  .NUM_HW(NUM_HW), .HW_POS(HW_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .hw_req(hw_req),
  .wr_en(wr_en), .wr_addr(wr_addr), .irq_line(irq_line),
  .msg_pulse(msg_pulse), .pend_q(pend_q)
);

// File: tb/irq_pend_agg_test.sv
module irq_pend_agg_test;
  localparam logic [7:0] ST = 8'h24, RA = 8'h60, CL = 8'h64;

  logic clk = 1'b0, rst_n = 1'b0, msg_mode = 1'b0, wr_en = 1'b0;
  logic [1:0] hw_req = '0;
  logic [7:0] wr_addr = '0, rd_addr = ST;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_line, msg_pulse;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] pend_m = '0;
  logic line_m = 1'b0, pulse_m = 1'b0;

  always #10 clk = ~clk;

  irq_pend_agg uut (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .hw_req(hw_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_line(irq_line), .msg_pulse(msg_pulse)
  );

  function automatic logic [31:0] next_pend(logic [31:0] p, logic we, logic [7:0] a,
                                            logic [31:0] d, logic [1:0] hw);
    logic [31:0] s, c;
    s = (we && a == RA) ? d : 32'h0;
    if (hw[0]) s[0] = 1'b1;
    if (hw[1]) s[8] = 1'b1;
    c = (we && a == CL) ? d : 32'h0;
    return (p & ~c) | s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [7:0] a, logic [31:0] d, logic [1:0] hw,
                     logic md, logic [7:0] ra, string tag);
    logic [31:0] pn;
    logic rs, cs;
    wr_en = we; wr_addr = a; wr_data = d; hw_req = hw; msg_mode = md; rd_addr = ra;
    pn = next_pend(pend_m, we, a, d, hw);
    rs = (we && a == RA) || (|hw);
    cs = we && a == CL;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; hw_req = '0;
    pend_m  = pn;
    pulse_m = md && rs && (pn != 0);
    if (!md) begin
      if (rs && pn != 0)       line_m = 1'b1;
      else if (cs && pn == 0)  line_m = 1'b0;
    end
    chk(ra == ST ? tag : "R12 read", rd_data, ra == ST ? pend_m : 32'h0);
    chk(md ? "R10 line" : "R7/R8 line", {31'b0, irq_line}, {31'b0, line_m});
    chk(md ? "R9 pulse" : "R11 pulse", {31'b0, msg_pulse}, {31'b0, pulse_m});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 pending", rd_data, 32'h0);
    chk("R1 line", {31'b0, irq_line}, 32'h0);
    chk("R1 pulse", {31'b0, msg_pulse}, 32'h0);
    rst_n = 1'b1;

    // level mode
    cyc(1, RA, 32'h5, 2'b00, 0, ST, "R2 raise");
    cyc(1, CL, 32'h1, 2'b00, 0, ST, "R3 partial clear");      // R8: line kept
    cyc(1, CL, 32'h4, 2'b00, 0, ST, "R3 clear all");          // R8: line drops
    cyc(0, 8'h0, 32'h0, 2'b01, 0, ST, "R4 compute bit");
    cyc(0, 8'h0, 32'h0, 2'b10, 0, ST, "R4 dma bit");
    cyc(1, CL, 32'h1, 2'b01, 0, ST, "R6 raise beats clear");
    cyc(1, RA, 32'h10, 2'b10, 0, ST, "R5 merge");
    cyc(1, 8'h10, 32'hFFFF_0000, 2'b00, 0, ST, "R12 unused write");
    cyc(0, 8'h0, 32'h0, 2'b00, 0, 8'h60, "R12");
    // message mode while line high
    cyc(1, RA, 32'h1, 2'b00, 1, ST, "R9 raise already pending");
    cyc(0, 8'h0, 32'h0, 2'b10, 1, ST, "R9 hw raise pending");
    cyc(1, CL, 32'hFFFF_FFFF, 2'b00, 1, ST, "R10 clear all msg");
    cyc(1, RA, 32'h0, 2'b00, 1, ST, "R9 empty raise");
    cyc(1, CL, 32'h0, 2'b00, 0, ST, "R8 level clear empty");
    cyc(1, RA, 32'h0, 2'b00, 0, ST, "R11 empty raise level");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic md;
      case ($urandom % 4)
        0: a = RA;
        1: a = CL;
        2: a = ST;
        default: a = 8'h10;
      endcase
      md = ($urandom % 8) < 3;
      cyc(($urandom % 2) == 1, a, $urandom & $urandom & $urandom,
          (($urandom % 5) == 0) ? 2'($urandom) : 2'b00, md,
          (($urandom % 10) == 0) ? 8'h64 : ST,
          a == CL ? "R3 random" : "R2/R5 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule